// File: doc/BRIEF.md
# T1 Receive Slip Buffer

This block is a two-frame elastic store that sits between a T1 receive line and a 32-slot serial system bus. The line side delivers 24 channel bytes per 125 µs frame, timed by the recovered line frame. The system side reads one byte per bus slot, 32 slots of 8 bit times each, timed by the system clock. Both sides are modelled as enable strobes in one clock domain: one strobe per written byte and one strobe per read bit time.

Because the two frame rates drift apart, the block checks at every read frame start whether the read side may safely take the most recently completed frame. When the read side has caught up with the frame that is still being written, it reads the previous frame again (a repeat). When the write side has lapped the read side, it skips one frame (a deletion). Each slip inverts a status bit and records its direction. At write frame boundaries the block also captures the read side's position, which gives the phase between the two frame boundaries, together with a flag that says whether the buffer delay is short or long.

Top module: `t1_rx_slip_buffer`

## Requirements
- R1: A write byte with `wr_sof` high is channel 0 of a new frame. The following write bytes fill channels 1 to 23 of that frame. Any further write bytes before the next `wr_sof` are ignored.
- R2: The read side counts bit times 0 to 7 within a slot and slots 0 to 31 within a frame, and both counts wrap to 0. On each read strobe at bit 0, `rd_valid` pulses for one cycle after the strobe, carrying that slot's number and byte. Slots 24 to 31 always carry 0xFF.
- R3: At each read frame start with no slip, the read side advances to the next frame, which is the most recently completed one. Slots 0 to 23 then carry that frame's channel bytes as stored at read time.
- R4: If at a read frame start the next frame is the one still being written (or one ahead of it), the current frame is read again. `slip_toggle` inverts and `slip_repeat` becomes 1.
- R5: If at a read frame start the write side is two frames beyond the next frame, that frame is skipped and the one after it is read. `slip_toggle` inverts and `slip_repeat` becomes 0.
- R6: `slip_toggle` and `slip_repeat` change only at a read frame start that slips. Otherwise they keep their values.
- R7: At a capturing write frame boundary, `phase_slots` and `phase_bits` take the read side's slot count and bit count: the number of whole slots and extra bit times that the read frame has advanced when the write frame starts.
- R8: At a capturing write frame boundary, `delay_short` becomes 1 if the frame being read is exactly two frames older than the frame now starting. Otherwise it becomes 0, meaning the delay exceeds one frame.
- R9: The phase word is captured at the 1st, 3rd, 5th and later odd write frame boundaries after reset, which is once every 250 µs. It holds its value at all other times.
- R10: After reset, `slip_toggle` and `slip_repeat` are 0 and `rd_valid` is 0. The phase word is `delay_short`=1 with 0 slots and 0 bits. The read side sits one frame behind the write side, so its first frame start takes the frame preceding the one being written without slipping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | One received channel byte is present |
| wr_sof | input | 1 | With `wr_en`: this byte is channel 0 of a new line frame |
| wr_data | input | 8 | Received channel byte |
| rd_bit_en | input | 1 | One system-bus bit time elapses |
| rd_byte | output | 8 | Byte for the slot just started |
| rd_valid | output | 1 | One-cycle pulse: `rd_byte` and `rd_slot` are new |
| rd_slot | output | 5 | Slot number belonging to `rd_byte` |
| slip_toggle | output | 1 | Inverts on every controlled slip |
| slip_repeat | output | 1 | Direction of the last slip: 1 repeat, 0 deletion |
| delay_short | output | 1 | Phase word MSB: 1 when the buffer delay is under one frame |
| phase_slots | output | 5 | Whole slots between the write and read frame boundaries |
| phase_bits | output | 3 | Extra bit times between the two boundaries |

## Verification
The bench targets three transitions. The first is a read frame start that lands on the frame still being filled: a design that skips instead of repeating delivers stale or future bytes in slots 0 to 23 and reports the wrong direction. The second is a line side that writes two frames within one read frame, where a design that misses the lap reads a half-overwritten bank. The bench also writes overlong frames: a channel counter that wraps corrupts channels 0 and 1 of the next read. Finally it moves the read position between write boundaries, so that a phase word refreshed on every boundary, or captured from the wrong counter, shows up at the ports.

// File: rtl/rsb_pkg.sv
// Shared types for the receive slip buffer.
// Frame indices count modulo four, so that "one frame ahead" and
// "two frames ahead" can be told apart with only two buffer banks.
package rsb_pkg;

    localparam int FIDX_W = 2;
    typedef logic [FIDX_W-1:0] fidx_t;

    // Read frame index after reset: the read side sits one frame behind the writer.
    localparam fidx_t RD_FRAME_RST = fidx_t'(2);

    typedef enum logic [1:0] {
        SLIP_NONE   = 2'd0,
        SLIP_REPEAT = 2'd1,
        SLIP_SKIP   = 2'd2
    } slip_e;

    // Decide the slip kind for a read frame start.
    // gap = distance from the frame the reader would take next to the frame being written.
    function automatic slip_e slip_kind(fidx_t wr_idx, fidx_t rd_idx);
        fidx_t gap;
        gap = wr_idx - rd_idx - fidx_t'(1);
        case (gap)
            fidx_t'(1): return SLIP_NONE;
            fidx_t'(2): return SLIP_SKIP;
            default:    return SLIP_REPEAT;
        endcase
    endfunction

    // Short-delay test at a write frame boundary (new write index vs read index).
    function automatic logic is_short_delay(fidx_t wr_new, fidx_t rd_idx);
        return (wr_new - rd_idx) == fidx_t'(2);
    endfunction

endpackage

// File: rtl/rsb_wr_side.sv
// Write side of the slip buffer.
// Tracks the frame being written (modulo four) and the channel within it,
// and produces the bank write port. Assumes wr_sof only arrives with wr_en.
module rsb_wr_side
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHANS  = 24,
    localparam int CH_W  = $clog2(CHANS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sof,
    input  logic [DATA_W-1:0] wr_data,
    output fidx_t             wr_frame,
    output logic              sof_stb,
    output logic              mem_we,
    output logic              mem_bank,
    output logic [CH_W-1:0]   mem_ch,
    output logic [DATA_W-1:0] mem_wdata
);

    localparam logic [CH_W-1:0] CH_FULL = CH_W'(CHANS);

    logic [CH_W-1:0] ch_q;
    fidx_t           frame_q;
    fidx_t           frame_inc;

    assign frame_inc = frame_q + fidx_t'(1);

    // Frame index and channel counter; the channel counter stops at CHANS.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            ch_q    <= CH_FULL;
        end else if (wr_en) begin
            if (wr_sof) begin
                frame_q <= frame_inc;
                ch_q    <= CH_W'(1);
            end else if (ch_q < CH_FULL) begin
                ch_q <= ch_q + CH_W'(1);
            end
        end
    end

    // Bank write port: channel 0 goes to the new frame's bank.
    always_comb begin
        mem_we    = wr_en && (wr_sof || (ch_q < CH_FULL));
        mem_bank  = wr_sof ? frame_inc[0] : frame_q[0];
        mem_ch    = wr_sof ? '0 : ch_q;
        mem_wdata = wr_data;
    end

    assign wr_frame = frame_q;
    assign sof_stb  = wr_en && wr_sof;

    AST_CH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ch_q <= CH_FULL);  // R1

    AST_EXTRA_BYTE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sof && ch_q == CH_FULL) |=> (ch_q == CH_FULL) && $stable(frame_q));  // R1

endmodule

// File: rtl/rsb_rd_timing.sv
// Read-side bus timing.
// Counts bit times within a slot and slots within a frame on each read strobe,
// and flags the strobes that open a slot or a frame.
module rsb_rd_timing #(
    parameter int SLOTS         = 32,
    parameter int BITS_PER_SLOT = 8,
    localparam int SLOT_W       = $clog2(SLOTS),
    localparam int BIT_W        = $clog2(BITS_PER_SLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_bit_en,
    output logic [SLOT_W-1:0] slot_cnt,
    output logic [BIT_W-1:0]  bit_cnt,
    output logic              slot_stb,
    output logic              frame_stb
);

    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(BITS_PER_SLOT - 1);

    // Position of the next read strobe; both counters wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt <= '0;
            bit_cnt  <= '0;
        end else if (rd_bit_en) begin
            if (bit_cnt == BIT_LAST) begin
                bit_cnt  <= '0;
                slot_cnt <= (slot_cnt == SLOT_LAST) ? '0 : slot_cnt + SLOT_W'(1);
            end else begin
                bit_cnt <= bit_cnt + BIT_W'(1);
            end
        end
    end

    assign slot_stb  = rd_bit_en && (bit_cnt == '0);
    assign frame_stb = slot_stb && (slot_cnt == '0);

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bit_en && slot_cnt == SLOT_LAST && bit_cnt == BIT_LAST) |=> (slot_cnt == '0) && (bit_cnt == '0));  // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_bit_en |=> $stable(slot_cnt) && $stable(bit_cnt));  // R2

endmodule

// File: rtl/rsb_slip_ctrl.sv
// Controlled-slip decision.
// At each read frame start, picks the next frame to read from the write
// frame index, repeating or skipping a frame when the reader is too close
// or too far, and records the slip as a toggle plus a direction bit.
module rsb_slip_ctrl
    import rsb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frame_stb,
    input  fidx_t wr_frame,
    output fidx_t rd_frame,
    output logic  rd_bank,
    output logic  slip_toggle,
    output logic  slip_repeat
);

    slip_e kind;
    fidx_t rd_next;
    fidx_t rd_q;

    // Choose the next read frame for the slip kind.
    always_comb begin
        kind = slip_kind(wr_frame, rd_q);
        case (kind)
            SLIP_REPEAT: rd_next = rd_q;
            SLIP_SKIP:   rd_next = rd_q + fidx_t'(2);
            default:     rd_next = rd_q + fidx_t'(1);
        endcase
        rd_bank = frame_stb ? rd_next[0] : rd_q[0];
    end

    // Read frame register and slip status, updated only at read frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q        <= RD_FRAME_RST;
            slip_toggle <= 1'b0;
            slip_repeat <= 1'b0;
        end else if (frame_stb) begin
            rd_q <= rd_next;
            if (kind != SLIP_NONE) begin
                slip_toggle <= ~slip_toggle;
                slip_repeat <= (kind == SLIP_REPEAT);
            end
        end
    end

    assign rd_frame = rd_q;

    AST_SLIP_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_toggle != $past(slip_toggle)) |-> $past(frame_stb));  // R6

    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(slip_repeat) && $stable(slip_toggle));  // R6

    AST_REPEAT_SAME_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && wr_frame == rd_q + fidx_t'(1)) |=> slip_repeat && (rd_q == $past(rd_q)));  // R4

    AST_SKIP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && wr_frame == rd_q + fidx_t'(3)) |=> !slip_repeat && (rd_q == $past(rd_q) + fidx_t'(2)));  // R5

endmodule

// File: rtl/rsb_phase_meter.sv
// Phase measurement between the write and read frame boundaries.
// On every other write frame boundary, captures the read slot and bit
// counts and whether the buffer delay is short; holds them otherwise.
module rsb_phase_meter
    import rsb_pkg::*;
#(
    parameter int SLOT_W = 5,
    parameter int BIT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_stb,
    input  fidx_t             wr_frame,
    input  fidx_t             rd_frame,
    input  logic [SLOT_W-1:0] slot_cnt,
    input  logic [BIT_W-1:0]  bit_cnt,
    output logic              delay_short,
    output logic [SLOT_W-1:0] phase_slots,
    output logic [BIT_W-1:0]  phase_bits
);

    logic take_q;   // 1 when the next write boundary is a capturing one

    // Alternate capture decision, starting with the first boundary after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b1;
        end else if (sof_stb) begin
            take_q <= ~take_q;
        end
    end

    // Phase word register, refreshed on capturing write boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_short <= 1'b1;
            phase_slots <= '0;
            phase_bits  <= '0;
        end else if (sof_stb && take_q) begin
            delay_short <= is_short_delay(wr_frame + fidx_t'(1), rd_frame);
            phase_slots <= slot_cnt;
            phase_bits  <= bit_cnt;
        end
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(sof_stb && take_q) |=> $stable(phase_slots) && $stable(phase_bits) && $stable(delay_short));  // R9

    AST_PHASE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_stb && take_q) |=> (phase_slots == $past(slot_cnt)) && (phase_bits == $past(bit_cnt)));  // R7

endmodule

// File: rtl/rsb_store.sv
// Two-frame byte store with the slot read-out register.
// Each bank holds one frame of channel bytes; a read strobe at a slot start
// loads the addressed byte, or the idle byte for unmapped slots.
module rsb_store #(
    parameter int DATA_W            = 8,
    parameter int CHANS             = 24,
    parameter int SLOTS             = 32,
    parameter logic [DATA_W-1:0] IDLE_BYTE = '1,
    localparam int CH_W             = $clog2(CHANS + 1),
    localparam int SLOT_W           = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wbank,
    input  logic [CH_W-1:0]   wch,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_stb,
    input  logic              rbank,
    input  logic [SLOT_W-1:0] rslot,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rd_valid,
    output logic [SLOT_W-1:0] rd_slot
);

    localparam int NBANK = 2;
    localparam logic [SLOT_W-1:0] SLOT_MAPPED = SLOT_W'(CHANS);

    logic [NBANK-1:0][DATA_W-1:0] bank_rd;
    logic [CH_W-1:0]              rd_idx;
    logic                         mapped;

    assign mapped = rslot < SLOT_MAPPED;
    assign rd_idx = mapped ? CH_W'(rslot) : '0;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DATA_W-1:0] mem_q [CHANS];

        // Bank storage, filled with idle bytes at reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int c = 0; c < CHANS; c++) begin
                    mem_q[c] <= IDLE_BYTE;
                end
            end else if (we && (wbank == 1'(b)) && (wch < CH_W'(CHANS))) begin
                mem_q[wch] <= wdata;
            end
        end

        assign bank_rd[b] = mem_q[rd_idx];
    end

    // Slot read-out register with a one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_byte  <= IDLE_BYTE;
            rd_valid <= 1'b0;
            rd_slot  <= '0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) begin
                rd_slot <= rslot;
                rd_byte <= mapped ? bank_rd[rbank] : IDLE_BYTE;
            end
        end
    end

    AST_IDLE_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_slot >= SLOT_MAPPED) |-> (rd_byte == IDLE_BYTE));  // R2

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);  // R2

endmodule

// File: rtl/t1_rx_slip_buffer.sv
// T1 receive slip buffer, top level.
// Connects the write side, the read timing, the slip decision, the phase
// meter and the two-frame store. Assumes both strobes share clk and that
// a write strobe and a read frame start do not need ordering between them:
// a read frame start sees the write frame index from before that cycle.
module t1_rx_slip_buffer
    import rsb_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int CHANS         = 24,
    parameter int SLOTS         = 32,
    parameter int BITS_PER_SLOT = 8,
    localparam int CH_W         = $clog2(CHANS + 1),
    localparam int SLOT_W       = $clog2(SLOTS),
    localparam int BIT_W        = $clog2(BITS_PER_SLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sof,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_bit_en,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rd_valid,
    output logic [SLOT_W-1:0] rd_slot,
    output logic              slip_toggle,
    output logic              slip_repeat,
    output logic              delay_short,
    output logic [SLOT_W-1:0] phase_slots,
    output logic [BIT_W-1:0]  phase_bits
);

    fidx_t             wr_frame;
    fidx_t             rd_frame;
    logic              sof_stb;
    logic              mem_we;
    logic              mem_bank;
    logic [CH_W-1:0]   mem_ch;
    logic [DATA_W-1:0] mem_wdata;
    logic [SLOT_W-1:0] slot_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic              slot_stb;
    logic              frame_stb;
    logic              rd_bank;

    rsb_wr_side #(.DATA_W(DATA_W), .CHANS(CHANS)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sof    (wr_sof),
        .wr_data   (wr_data),
        .wr_frame  (wr_frame),
        .sof_stb   (sof_stb),
        .mem_we    (mem_we),
        .mem_bank  (mem_bank),
        .mem_ch    (mem_ch),
        .mem_wdata (mem_wdata)
    );

    rsb_rd_timing #(.SLOTS(SLOTS), .BITS_PER_SLOT(BITS_PER_SLOT)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_bit_en (rd_bit_en),
        .slot_cnt  (slot_cnt),
        .bit_cnt   (bit_cnt),
        .slot_stb  (slot_stb),
        .frame_stb (frame_stb)
    );

    rsb_slip_ctrl u_slip (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_stb   (frame_stb),
        .wr_frame    (wr_frame),
        .rd_frame    (rd_frame),
        .rd_bank     (rd_bank),
        .slip_toggle (slip_toggle),
        .slip_repeat (slip_repeat)
    );

    rsb_phase_meter #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_stb     (sof_stb),
        .wr_frame    (wr_frame),
        .rd_frame    (rd_frame),
        .slot_cnt    (slot_cnt),
        .bit_cnt     (bit_cnt),
        .delay_short (delay_short),
        .phase_slots (phase_slots),
        .phase_bits  (phase_bits)
    );

    rsb_store #(.DATA_W(DATA_W), .CHANS(CHANS), .SLOTS(SLOTS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (mem_we),
        .wbank    (mem_bank),
        .wch      (mem_ch),
        .wdata    (mem_wdata),
        .rd_stb   (slot_stb),
        .rbank    (rd_bank),
        .rslot    (slot_cnt),
        .rd_byte  (rd_byte),
        .rd_valid (rd_valid),
        .rd_slot  (rd_slot)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(!rst_n) |-> !slip_toggle && !slip_repeat && delay_short && !rd_valid);  // R10

endmodule

// File: tb/t1_rx_slip_buffer_bench.sv
`timescale 1ns/1ps
module t1_rx_slip_buffer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sof = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_bit_en = 1'b0;
    logic [7:0] rd_byte;
    logic       rd_valid;
    logic [4:0] rd_slot;
    logic       slip_toggle;
    logic       slip_repeat;
    logic       delay_short;
    logic [4:0] phase_slots;
    logic [2:0] phase_bits;

    always #4 clk = ~clk;  // 125 MHz

    t1_rx_slip_buffer u_t1_rx_slip_buffer (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sof      (wr_sof),
        .wr_data     (wr_data),
        .rd_bit_en   (rd_bit_en),
        .rd_byte     (rd_byte),
        .rd_valid    (rd_valid),
        .rd_slot     (rd_slot),
        .slip_toggle (slip_toggle),
        .slip_repeat (slip_repeat),
        .delay_short (delay_short),
        .phase_slots (phase_slots),
        .phase_bits  (phase_bits)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [12:0] exp_q [$];

    // Bench model of the requirements.
    int bwf = 0, brf = 2, bslot = 0, bbit = 0, bwch = 24, bcap = 1, fid = 0;
    logic [7:0] shadow [2][24];
    int e_tgl = 0, e_dir = 0, e_flag = 1, e_slots = 0, e_bits = 0;
    string slip_tag = "R3";
    string phase_tag = "R10";

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pop the expected slot items as the design produces them.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2 unexpected slot output: actual %0d expected none", rd_slot);
            end else begin
                logic [12:0] e;
                e = exp_q.pop_front();
                check(e[12:8] >= 24 ? "R2" : "R3", "slot/byte", {rd_slot, rd_byte}, e);
            end
        end
    end

    // Driver: one read bit strobe; pushes the expected byte at slot starts.
    task automatic rd_strobe();
        bit fs;
        fs = (bslot == 0) && (bbit == 0);
        @(negedge clk);
        if (bbit == 0) begin
            if (fs) begin
                int gap;
                gap = (bwf - brf - 1) & 3;
                if (gap == 1) begin
                    brf = (brf + 1) & 3; slip_tag = "R3";
                end else if (gap == 2) begin
                    brf = (brf + 2) & 3; e_tgl ^= 1; e_dir = 0; slip_tag = "R5";
                end else begin
                    e_tgl ^= 1; e_dir = 1; slip_tag = "R4";
                end
            end
            exp_q.push_back({5'(bslot), (bslot < 24) ? shadow[brf & 1][bslot] : 8'hFF});
        end
        rd_bit_en = 1'b1;
        bbit++;
        if (bbit == 8) begin bbit = 0; bslot = (bslot + 1) % 32; end
        @(negedge clk);
        rd_bit_en = 1'b0;
        if (fs) begin
            check(slip_tag == "R3" ? "R6" : slip_tag, "slip_toggle", slip_toggle, e_tgl);
            check(slip_tag == "R3" ? "R6" : slip_tag, "slip_repeat", slip_repeat, e_dir);
        end
    endtask

    // Driver: one write byte.
    task automatic wr_byte(bit sof, logic [7:0] d);
        @(negedge clk);
        if (sof) begin
            bwf = (bwf + 1) & 3;
            if (bcap == 1) begin
                e_flag = (((bwf - brf) & 3) == 2) ? 1 : 0;
                e_slots = bslot; e_bits = bbit; phase_tag = "R7";
            end else begin
                phase_tag = "R9";
            end
            bcap ^= 1;
            shadow[bwf & 1][0] = d;
            bwch = 1;
        end else if (bwch < 24) begin
            shadow[bwf & 1][bwch] = d;
            bwch++;
        end
        wr_en = 1'b1; wr_sof = sof; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sof = 1'b0;
    endtask

    task automatic wr_frame(int nbytes);
        fid++;
        for (int c = 0; c < nbytes; c++) begin
            wr_byte(c == 0, 8'(fid * 37 + c * 5 + 1));
            if (c == 0) begin
                check(phase_tag, "phase_slots", phase_slots, e_slots);
                check(phase_tag, "phase_bits", phase_bits, e_bits);
                check(phase_tag == "R7" ? "R8" : "R9", "delay_short", delay_short, e_flag);
            end
        end
    endtask

    // One read frame with nwr write frames placed after 'split' bit times.
    task automatic period(int split, int nwr, int nbytes);
        for (int i = 0; i < split; i++) rd_strobe();
        for (int w = 0; w < nwr; w++) wr_frame(nbytes);
        for (int i = split; i < 256; i++) rd_strobe();
    endtask

    initial begin
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < 24; c++) shadow[b][c] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10", "slip_toggle", slip_toggle, 0);
        check("R10", "slip_repeat", slip_repeat, 0);
        check("R10", "rd_valid", rd_valid, 0);
        check("R10", "delay_short", delay_short, 1);
        check("R10", "phase_slots", phase_slots, 0);
        check("R10", "phase_bits", phase_bits, 0);

        // R3 steady flow, R7 R9 phase captured at alternating read positions
        period(100, 1, 24);
        period(60, 1, 24);
        period(100, 1, 24);
        period(77, 1, 24);
        // R4 read side faster: an extra read frame with no write
        period(0, 0, 24);
        period(100, 1, 24);
        period(45, 1, 24);
        // R5 write side faster: two write frames in one read frame
        period(100, 2, 24);
        period(100, 1, 24);
        // R1 overlong write frames
        period(80, 1, 26);
        period(90, 1, 30);
        period(100, 1, 24);
        // R4 again, then R5 again, checks R6 direction tracking
        period(0, 0, 24);
        period(30, 2, 24);
        period(100, 1, 24);

        repeat (4) @(negedge clk);
        check("R2", "pending slot items", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule